// File: doc/BRIEF.md
# Conversion Result Accumulator and Formatter

This block sits behind a 12-bit converter and turns its stream of unsigned samples into a 16-bit result word. A two-bit repeat setting selects how many samples make up one set: 1, 4, 8 or 16. The samples of a set are summed internally. When the last sample of the set arrives, the sum is formatted and latched into the visible result. The result is presented as a high byte and a low byte. A single-sample result may be placed at the low end (right-justified) or the high end (left-justified) of the word. A summed result is always placed at the low end.

When a set completes, the block raises a sticky completion flag that stays high until a clear input is pulsed. In the same cycle it issues a one-cycle strobe that tells a downstream window detector the new result is ready for comparison. Deasserting the enable input abandons any set in progress: the partial sum and the sample count both return to zero. Samples that arrive while the block is disabled are ignored. The previously latched result is kept.

Top module: `adc_result_accum`

## Requirements
- R1: The repeat code selects the set size: 2'b00 means 1 sample, 2'b01 means 4, 2'b10 means 8 and 2'b11 means 16 samples per set.
- R2: With a set size of one and the justify input low, the 12-bit sample occupies result bits 11..0 and bits 15..12 are zero (full scale reads 16'h0FFF).
- R3: With a set size of one and the justify input high, the sample occupies result bits 15..4 and bits 3..0 are zero (full scale reads 16'hFFF0).
- R4: For set sizes above one, the result is the unsigned sum of the samples, right-justified. Full-scale samples give 16'h3FFC for four, 16'h7FF8 for eight and 16'hFFF0 for sixteen.
- R5: The result word changes only when a set completes. It shows the new value from the first clock edge after the edge that accepted the last sample of the set.
- R6: The internal sum returns to zero when a set completes, so the next set never carries earlier samples.
- R7: The completion flag rises together with the new result and stays high until the clear input is seen. If a set completes in the same cycle as a clear, the flag ends up set.
- R8: The compare strobe is high for exactly the cycle in which a new result first appears, and only then.
- R9: When the set size is above one, the justify input has no effect and the result stays right-justified.
- R10: While enable is low, samples are not accepted, the partial sum and the sample count are zero, and the latched result is held.
- R11: After reset, the result is 16'h0000 and both the completion flag and the compare strobe are low.
- R12: The high-byte output carries result bits 15..8 and the low-byte output carries bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enabled; low abandons a set in progress |
| sampleValid | input | 1 | A new sample is present on sampleData |
| sampleData | input | 12 | Unsigned converter sample |
| repeatCode | input | 2 | Set-size selection |
| leftJustify | input | 1 | Justify request for single-sample results |
| clearDone | input | 1 | Clears the completion flag |
| resultHigh | output | 8 | Result bits 15..8 |
| resultLow | output | 8 | Result bits 7..0 |
| convDone | output | 1 | Sticky completion flag |
| cmpStrobe | output | 1 | One-cycle pulse when a new result appears |

## Verification
Two events can land on the completion flag in the same cycle: a set can complete while the clear input is asserted. The bench provokes this by driving the final sample of a set and the clear together on one edge. It then expects the flag to read high on the following edge and to drop only after a later, lone clear. A second pairing is also tested: the enable input falls on the same edge that offers a sample. The bench expects the sample to be dropped, and it checks that a fresh set then produces a sum made only of later samples.

// File: rtl/adc_accum_pkg.sv
package adc_accum_pkg;

  typedef struct packed {
    logic accumEn;
    logic accumClear;
    logic loadResult;
    logic singleMode;
  } accCtl_t;

  function automatic int unsigned repeatShift(input logic [1:0] code);
    case (code)
      2'b00:   repeatShift = 0;
      2'b01:   repeatShift = 2;
      2'b10:   repeatShift = 3;
      default: repeatShift = 4;
    endcase
  endfunction

endpackage

// File: rtl/adc_accum_ctrl.sv
module adc_accum_ctrl
  import adc_accum_pkg::*;
#(
  parameter int MAX_SHIFT = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      sampleValid,
  input  logic [1:0] repeatCode,
  input  logic      clearDone,
  output accCtl_t   ctl,
  output logic      convDone,
  output logic      cmpStrobe
);
  localparam int CNT_W = MAX_SHIFT;

  logic [CNT_W-1:0] sampleCount;
  logic [CNT_W-1:0] lastIdx;
  logic             accept;
  logic             lastNow;

  always_comb begin
    lastIdx = CNT_W'((1 << repeatShift(repeatCode)) - 1);
    accept  = enable && sampleValid;
    lastNow = accept && (sampleCount >= lastIdx);
    ctl.accumEn    = accept && !lastNow;
    ctl.accumClear = lastNow || !enable;
    ctl.loadResult = lastNow;
    ctl.singleMode = (repeatCode == 2'b00);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCount <= '0;
    end else if (!enable || lastNow) begin
      sampleCount <= '0;
    end else if (accept) begin
      sampleCount <= sampleCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convDone  <= 1'b0;
      cmpStrobe <= 1'b0;
    end else begin
      cmpStrobe <= lastNow;
      if (lastNow) begin
        convDone <= 1'b1;
      end else if (clearDone) begin
        convDone <= 1'b0;
      end
    end
  end

  assert_idle_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sampleCount == '0));
  assert_done_after_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadResult |=> convDone);
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clearDone && !ctl.loadResult) |=> !convDone);
  assert_strobe_follows_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadResult |=> cmpStrobe);

endmodule

// File: rtl/adc_accum_data.sv
module adc_accum_data
  import adc_accum_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int MAX_SHIFT = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  accCtl_t                       ctl,
  input  logic [SAMPLE_W-1:0]           sampleData,
  input  logic                          leftJustify,
  output logic [SAMPLE_W+MAX_SHIFT-1:0] resultWord
);
  localparam int RESULT_W = SAMPLE_W + MAX_SHIFT;
  localparam int PAD_W    = RESULT_W - SAMPLE_W;

  logic [RESULT_W-1:0] accum;
  logic [RESULT_W-1:0] sumNext;
  logic [RESULT_W-1:0] formatted;

  always_comb begin
    sumNext = accum + RESULT_W'(sampleData);
    if (ctl.singleMode && leftJustify) begin
      formatted = {sampleData, {PAD_W{1'b0}}};
    end else begin
      formatted = sumNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accum <= '0;
    end else if (ctl.accumClear) begin
      accum <= '0;
    end else if (ctl.accumEn) begin
      accum <= sumNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultWord <= '0;
    end else if (ctl.loadResult) begin
      resultWord <= formatted;
    end
  end

  assert_right_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadResult && ctl.singleMode && !leftJustify)
      |=> (resultWord[RESULT_W-1:SAMPLE_W] == '0));
  assert_left_lower_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadResult && ctl.singleMode && leftJustify)
      |=> (resultWord[PAD_W-1:0] == '0));
  assert_fresh_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadResult |=> (accum == '0));

endmodule

// File: rtl/adc_result_accum.sv
module adc_result_accum
  import adc_accum_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int MAX_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [1:0]          repeatCode,
  input  logic                leftJustify,
  input  logic                clearDone,
  output logic [7:0]          resultHigh,
  output logic [7:0]          resultLow,
  output logic                convDone,
  output logic                cmpStrobe
);
  localparam int RESULT_W = SAMPLE_W + MAX_SHIFT;

  accCtl_t             ctl;
  logic [RESULT_W-1:0] resultWord;

  adc_accum_ctrl #(.MAX_SHIFT(MAX_SHIFT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sampleValid(sampleValid),
    .repeatCode (repeatCode),
    .clearDone  (clearDone),
    .ctl        (ctl),
    .convDone   (convDone),
    .cmpStrobe  (cmpStrobe)
  );

  adc_accum_data #(.SAMPLE_W(SAMPLE_W), .MAX_SHIFT(MAX_SHIFT)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sampleData (sampleData),
    .leftJustify(leftJustify),
    .resultWord (resultWord)
  );

  assign resultHigh = resultWord[RESULT_W-1:RESULT_W-8];
  assign resultLow  = resultWord[7:0];

  assert_result_moves_on_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultWord) |-> cmpStrobe);
  assert_strobe_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |-> convDone);

endmodule

// File: tb/sim_adc_result_accum.sv
module sim_adc_result_accum;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic [1:0]  repeatCode = '0;
  logic        leftJustify = 1'b0;
  logic        clearDone = 1'b0;
  logic [7:0]  resultHigh, resultLow;
  logic        convDone, cmpStrobe;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  adc_result_accum u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleValid(sampleValid),
    .sampleData(sampleData), .repeatCode(repeatCode), .leftJustify(leftJustify),
    .clearDone(clearDone), .resultHigh(resultHigh), .resultLow(resultLow),
    .convDone(convDone), .cmpStrobe(cmpStrobe)
  );

  // vector: {repeatCode[30:29], leftJustify[28], sample[27:16], expected[15:0]}
  localparam int NV = 12;
  localparam logic [30:0] VECS [NV] = '{
    {2'b00, 1'b0, 12'hFFF, 16'h0FFF},
    {2'b00, 1'b1, 12'hFFF, 16'hFFF0},
    {2'b00, 1'b0, 12'h800, 16'h0800},
    {2'b00, 1'b1, 12'h7FF, 16'h7FF0},
    {2'b01, 1'b0, 12'hFFF, 16'h3FFC},
    {2'b10, 1'b0, 12'hFFF, 16'h7FF8},
    {2'b11, 1'b0, 12'hFFF, 16'hFFF0},
    {2'b01, 1'b1, 12'h800, 16'h2000},
    {2'b11, 1'b1, 12'h7FF, 16'h7FF0},
    {2'b10, 1'b0, 12'h000, 16'h0000},
    {2'b00, 1'b1, 12'h000, 16'h0000},
    {2'b10, 1'b1, 12'h7FF, 16'h3FF8}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] d);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = d;
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    clearDone = 1'b1;
    @(negedge clk);
    clearDone = 1'b0;
  endtask

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] prevRes;
    repeat (3) @(negedge clk);
    check("R11 result", {resultHigh, resultLow}, 16'h0000);
    check("R11 done", convDone, 1'b0);
    check("R11 strobe", cmpStrobe, 1'b0);
    rstN = 1'b1;
    enable = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      repeatCode  = VECS[v][30:29];
      leftJustify = VECS[v][28];
      clearFlag();
      prevRes = {resultHigh, resultLow};
      for (int s = 0; s < (1 << ((VECS[v][30:29] == 2'b00) ? 0 : VECS[v][30:29] + 1)); s++) begin
        push(VECS[v][27:16]);
        if (s < (1 << ((VECS[v][30:29] == 2'b00) ? 0 : VECS[v][30:29] + 1)) - 1) begin
          check("R5 result held mid-set", {resultHigh, resultLow}, prevRes);
          check("R5 done low mid-set", convDone, 1'b0);
        end
      end
      // R1 R2 R3 R4 R9 R12: formatted value after set completes
      check($sformatf("R1/R4/R9 vec%0d word", v), {resultHigh, resultLow}, VECS[v][15:0]);
      check("R12 high byte", resultHigh, VECS[v][15:8]);
      check("R8 strobe on update", cmpStrobe, 1'b1);
      check("R7 done set", convDone, 1'b1);
      @(negedge clk);
      check("R8 strobe single cycle", cmpStrobe, 1'b0);
      check("R7 done sticky", convDone, 1'b1);
    end

    // R6: mixed values across two consecutive sets of four
    repeatCode = 2'b01; leftJustify = 1'b0;
    push(12'h001); push(12'h010); push(12'h100); push(12'h123);
    check("R6 first set", {resultHigh, resultLow}, 16'h0234);
    push(12'h005); push(12'h006); push(12'h007); push(12'h008);
    check("R6 fresh second set", {resultHigh, resultLow}, 16'h001A);

    // R10: disable mid-set abandons partial sum; result held; samples ignored
    clearFlag();
    push(12'hAAA); push(12'hBBB);
    @(negedge clk); enable = 1'b0;
    push(12'hFFF); push(12'hFFF); push(12'hFFF); push(12'hFFF);
    check("R10 result held while off", {resultHigh, resultLow}, 16'h001A);
    check("R10 no completion while off", convDone, 1'b0);
    // same edge: enable low and sample offered -> dropped
    @(negedge clk); sampleValid = 1'b1; sampleData = 12'h777;
    @(negedge clk); sampleValid = 1'b0; enable = 1'b1;
    push(12'h002); push(12'h002); push(12'h002);
    check("R10 partial set not done", convDone, 1'b0);
    push(12'h002);
    check("R10 restarted sum", {resultHigh, resultLow}, 16'h0008);

    // R7: completion and clear in the same cycle -> set wins
    repeatCode = 2'b00;
    @(negedge clk);
    sampleValid = 1'b1; sampleData = 12'h321; clearDone = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0; clearDone = 1'b0;
    check("R7 set beats clear", convDone, 1'b1);
    check("R2 single value", {resultHigh, resultLow}, 16'h0321);
    clearFlag();
    check("R7 lone clear", convDone, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule